// File: doc/BRIEF.md
# Multichannel PWM Generator with Boundary-Committed Settings

This block drives a small set of independent pulse-width-modulated outputs from a single-cycle register port. Each channel owns three 32-bit words: a cycle length, an on-time and a mode word. The mode word carries a power-of-two tick divider select and an output inversion bit. Every write lands in a staging copy. The output keeps running on the live copy until the cycle-length word is written. Then the whole staged set moves into the live copy at once, at the end of the cycle that is running.

All channels count a shared base tick (nominally one enable pulse per microsecond) after their own divider. Writing zero as the cycle length stops a channel gracefully. The cycle in flight runs to its end, and the output then rests low. A stopped channel restarts as soon as a nonzero cycle length is written.

Top module: `pwm_shadow_ctrl`

## Requirements
- R1: After reset every output is low, every register reads zero, and no channel is counting.
- R2: Channel c has its cycle-length word at byte offset 0x400+4c, its on-time word at 0x420+4c and its mode word at 0x440+4c. The cycle-length and on-time words keep bits [15:0]. The mode word keeps the divider select in bits [1:0] and the inversion bit in bit 5. A read returns the staged value with every other bit zero.
- R3: A write to an offset that is unaligned, outside the three ranges, or names a channel at or above N_CH changes nothing. A read of such an offset returns zero.
- R4: Writes to the on-time and mode words alone never change the output waveform.
- R5: When a stopped channel gets a nonzero cycle-length write, the staged settings go live two clocks after the write cycle. The counter starts at 0 and advances on the next divided tick.
- R6: With inversion off, the output is high while the in-cycle count is below the on-time, and low for the rest of a cycle of cycle-length counts. An on-time of 0 gives constant low. An on-time at or above the cycle length gives constant high.
- R7: Divider select 0, 1, 2 and 3 advances the count once every 1, 2, 4 and 8 base ticks. The divider restarts whenever settings go live.
- R8: With the inversion bit set, a running channel drives the complement of the R6 waveform.
- R9: A cycle-length write on a running channel arms an update. All three staged words go live together at the first cycle end reached in a clock cycle after the write cycle. A cycle end that falls in the write cycle itself wraps with the old settings.
- R10: A zero cycle-length write lets the current cycle finish, then holds the output low whatever the inversion bit.
- R11: Channels run independently: settings of one never alter the waveform of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Base counting tick enable, one clock wide |
| wr_en_i | input | 1 | Register write strobe for this cycle |
| addr_i | input | ADDR_W | Byte offset of the register accessed |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i, combinational |
| pwm_o | output | N_CH | One waveform output per channel |

## Verification
A cycle end and a cycle-length write can land in the same clock cycle. That is the one race in the block. The bench provokes it by raising the write strobe and the base tick together, at the moment the counter holds its last value. It expects the old settings to wrap for one more full cycle before the new ones take over. The same sequence with the write placed between ticks has to switch at that same boundary. Comparing the two cases pins down the exact cycle-end rule.

// File: rtl/pwm_shadow_pkg.sv
// Shared constants and types for the PWM generator.
// Assumes a byte-addressed register space with 32-bit words.
package pwm_shadow_pkg;

    localparam int CNT_W     = 16;      // width of count, cycle length and on-time
    localparam int SEL_W     = 2;       // divider select width (divide by 2**sel)
    localparam int POL_BIT   = 5;       // mode word bit holding output inversion
    localparam int MAX_CH    = 8;       // address space room per word group
    localparam int SLOT_LSB  = 5;       // each word group spans 32 bytes
    localparam int CH_W      = SLOT_LSB - 2;
    localparam int LEN_BASE  = 32'h400;
    localparam int ON_BASE   = 32'h420;
    localparam int MODE_BASE = 32'h440;

    typedef enum logic [1:0] {
        KIND_LEN  = 2'd0,
        KIND_ON   = 2'd1,
        KIND_MODE = 2'd2,
        KIND_NONE = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic             inv;
        logic [SEL_W-1:0] div_sel;
        logic [CNT_W-1:0] on_time;
        logic [CNT_W-1:0] cyc_len;
    } chan_cfg_t;

endpackage

// File: rtl/pwm_regfile.sv
// Register decode and staging storage for all channels.
// Assumes single-cycle writes and combinational reads; raises a one-clock
// arm pulse for a channel the cycle after its cycle-length word is written.
module pwm_regfile
    import pwm_shadow_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [DATA_W-1:0]      wdata_i,
    output logic [DATA_W-1:0]      rdata_o,
    output chan_cfg_t [N_CH-1:0]   cfg_o,
    output logic [N_CH-1:0]        arm_o
);

    localparam int TAG_W = ADDR_W - SLOT_LSB;
    localparam logic [TAG_W-1:0] LEN_TAG  = TAG_W'(LEN_BASE  >> SLOT_LSB);
    localparam logic [TAG_W-1:0] ON_TAG   = TAG_W'(ON_BASE   >> SLOT_LSB);
    localparam logic [TAG_W-1:0] MODE_TAG = TAG_W'(MODE_BASE >> SLOT_LSB);
    localparam logic [CH_W:0]    CH_LIM   = (CH_W + 1)'(N_CH);

    chan_cfg_t [N_CH-1:0] stage_q;
    logic [N_CH-1:0]      arm_q;
    reg_kind_e            kind;
    logic [CH_W-1:0]      ch_sel;
    logic                 hit;
    chan_cfg_t            rd_cfg;
    logic                 unused_wdata;

    assign unused_wdata = ^wdata_i;

    // Decode the offset into word kind, channel index and validity.
    always_comb begin
        ch_sel = addr_i[SLOT_LSB-1:2];
        if (addr_i[ADDR_W-1:SLOT_LSB] == LEN_TAG)       kind = KIND_LEN;
        else if (addr_i[ADDR_W-1:SLOT_LSB] == ON_TAG)   kind = KIND_ON;
        else if (addr_i[ADDR_W-1:SLOT_LSB] == MODE_TAG) kind = KIND_MODE;
        else                                            kind = KIND_NONE;
        hit = (addr_i[1:0] == 2'b00) && ({1'b0, ch_sel} < CH_LIM)
              && (kind != KIND_NONE);
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_stage
        // Capture staged words and flag cycle-length writes for channel c.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[c] <= '0;
                arm_q[c]   <= 1'b0;
            end else begin
                arm_q[c] <= wr_en_i && hit && (kind == KIND_LEN)
                            && (ch_sel == CH_W'(c));
                if (wr_en_i && hit && (ch_sel == CH_W'(c))) begin
                    case (kind)
                        KIND_LEN:  stage_q[c].cyc_len <= wdata_i[CNT_W-1:0];
                        KIND_ON:   stage_q[c].on_time <= wdata_i[CNT_W-1:0];
                        KIND_MODE: begin
                            stage_q[c].div_sel <= wdata_i[SEL_W-1:0];
                            stage_q[c].inv     <= wdata_i[POL_BIT];
                        end
                        default: ;
                    endcase
                end
            end
        end

        // An arm pulse only ever follows a write strobe (R9).
        p_arm_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
            arm_o[c] |-> $past(wr_en_i));
    end

    // Pick the staged set of the addressed channel.
    always_comb begin
        rd_cfg = '0;
        for (int c = 0; c < N_CH; c++) begin
            if (ch_sel == CH_W'(c)) rd_cfg = stage_q[c];
        end
    end

    // Form read data from the staged set, zero outside the map.
    always_comb begin
        rdata_o = '0;
        if (hit) begin
            case (kind)
                KIND_LEN:  rdata_o[CNT_W-1:0] = rd_cfg.cyc_len;
                KIND_ON:   rdata_o[CNT_W-1:0] = rd_cfg.on_time;
                KIND_MODE: begin
                    rdata_o[SEL_W-1:0] = rd_cfg.div_sel;
                    rdata_o[POL_BIT]   = rd_cfg.inv;
                end
                default: ;
            endcase
        end
    end

    assign cfg_o = stage_q;
    assign arm_o = arm_q;

    // Writes outside the map leave every staged word untouched (R3).
    p_unmapped_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !hit) |=> $stable(stage_q));

endmodule

// File: rtl/pwm_prescaler.sv
// Power-of-two divider of the base tick for one channel.
// Assumes tick_i is a one-clock enable; restart_i realigns the divider.
module pwm_prescaler
    import pwm_shadow_pkg::*;
#(
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          restart_i,
    input  logic [SW-1:0] sel_i,
    output logic          ptick_o
);

    localparam int DIV_W = (1 << SW) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    // Build a mask of sel_i low ones.
    always_comb begin
        mask = '0;
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i < int'(sel_i));
        end
    end

    assign ptick_o = tick_i && ((div_q & mask) == mask);

    // Count base ticks, restarting from zero on a settings load.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) div_q <= '0;
        else if (tick_i)         div_q <= div_q + 1'b1;
    end

    // Right after a restart only the undivided setting may fire (R7).
    p_restart_realign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (!ptick_o || sel_i == '0));

endmodule

// File: rtl/pwm_channel.sv
// One PWM channel: live settings, in-cycle counter, update arming, output.
// Assumes arm_i pulses one clock after cfg_i already holds the new set.
module pwm_channel
    import pwm_shadow_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    input  logic      arm_i,
    input  chan_cfg_t cfg_i,
    output logic      pwm_o
);

    chan_cfg_t        live_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;
    logic             running;
    logic             at_last;
    logic             ptick;
    logic             cyc_end;
    logic             load;

    pwm_prescaler #(.SW(SEL_W)) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .restart_i(load),
        .sel_i    (live_q.div_sel),
        .ptick_o  (ptick)
    );

    // Decide when a staged set goes live.
    always_comb begin
        running = (live_q.cyc_len != '0);
        at_last = (cnt_q == live_q.cyc_len - 1'b1);
        cyc_end = running && ptick && at_last;
        load    = (!running && arm_i) || (cyc_end && (pend_q || arm_i));
    end

    // Hold the live settings and the pending-update flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            pend_q <= 1'b0;
        end else if (load) begin
            live_q <= cfg_i;
            pend_q <= 1'b0;
        end else if (arm_i) begin
            pend_q <= 1'b1;
        end
    end

    // Advance the in-cycle counter on divided ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || load)      cnt_q <= '0;
        else if (running && ptick) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end

    assign pwm_o = running && ((cnt_q < live_q.on_time) ^ live_q.inv);

    // The counter never leaves the running cycle (R6).
    p_cnt_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt_q < live_q.cyc_len));

    // Live settings only change at a cycle end while running (R9).
    p_commit_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !cyc_end) |=> $stable(live_q));

    // A channel stops only where a cycle ends (R10).
    p_stop_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> $past(cyc_end));

endmodule

// File: rtl/pwm_shadow_ctrl.sv
// Top of the multichannel PWM generator with staged, boundary-committed
// settings. Assumes 1 <= N_CH <= 8 and ADDR_W >= 11.
module pwm_shadow_ctrl
    import pwm_shadow_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [N_CH-1:0]   pwm_o
);

    chan_cfg_t [N_CH-1:0] stage_cfg;
    logic [N_CH-1:0]      arm;

    pwm_regfile #(.N_CH(N_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en_i(wr_en_i),
        .addr_i (addr_i),
        .wdata_i(wdata_i),
        .rdata_o(rdata_o),
        .cfg_o  (stage_cfg),
        .arm_o  (arm)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        pwm_channel i_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .tick_i(tick_i),
            .arm_i (arm[c]),
            .cfg_i (stage_cfg[c]),
            .pwm_o (pwm_o[c])
        );
    end

    // Outputs are low during the first cycle after reset (R1).
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pwm_o == '0));

endmodule

// File: tb/test_pwm_shadow_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
module test_pwm_shadow_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  pwm;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    pwm_shadow_ctrl #(.N_CH(4), .ADDR_W(12), .DATA_W(32)) i_pwm_shadow_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic step();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Base tick and cycle-length write in the very same clock cycle.
    task automatic step_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Compare n samples of channel ch against the R6/R7/R8 waveform model.
    task automatic check_wave(input int ch, input int len, input int on, input int sel,
                              input int inv, input int k0, input int n, input string req);
        bit ok = 1'b1;
        int bad_k = 0;
        logic got = 1'b0, want = 1'b0;
        for (int k = 0; k < n; k++) begin
            logic e;
            e = logic'((((k0 + k) >> sel) % len) < on) ^ logic'(inv);
            if (ok && pwm[ch] !== e) begin
                ok = 1'b0; bad_k = k0 + k; got = pwm[ch]; want = e;
            end
            step();
        end
        if (!ok) $display("FAIL %s mismatch at tick %0d", req, bad_k);
        check(ok, req, longint'(got), longint'(want));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        check(pwm == 4'b0, "R1 outputs", longint'(pwm), 0);
        bus_read(12'h400, d); check(d == 0, "R1 len0", d, 0);
        bus_read(12'h424, d); check(d == 0, "R1 on1", d, 0);
        bus_read(12'h448, d); check(d == 0, "R1 mode2", d, 0);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        do_reset();
        bus_write(12'h40C, 32'hFFFF_ABCD);
        bus_read(12'h40C, d); check(d == 32'h0000_ABCD, "R2 len3", d, 32'hABCD);
        bus_write(12'h428, 32'h0001_2345);
        bus_read(12'h428, d); check(d == 32'h0000_2345, "R2 on2", d, 32'h2345);
        bus_write(12'h444, 32'hFFFF_FFFF);
        bus_read(12'h444, d); check(d == 32'h0000_0023, "R2 mode1", d, 32'h23);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bit ok = 1'b1;
        do_reset();
        bus_write(12'h450, 32'h3);
        bus_read(12'h450, d); check(d == 0, "R3 channel4", d, 0);
        bus_write(12'h401, 32'h5);
        bus_read(12'h400, d); check(d == 0, "R3 unaligned", d, 0);
        bus_write(12'h010, 32'h7);
        bus_read(12'h010, d); check(d == 0, "R3 outside", d, 0);
        for (int c = 0; c < 4; c++) begin
            bus_read(12'(12'h440 + 4 * c), d);
            if (d != 0) ok = 1'b0;
        end
        check(ok, "R3 mode words intact", longint'(ok), 1);
        for (int k = 0; k < 4; k++) step();
        check(pwm == 4'b0, "R3 outputs idle", longint'(pwm), 0);
    endtask

    task automatic t_basic();
        do_reset();
        bus_write(12'h420, 32'd3);
        bus_write(12'h400, 32'd5);
        check(pwm[0] === 1'b1, "R5 starts high before first tick", longint'(pwm[0]), 1);
        check_wave(0, 5, 3, 0, 0, 0, 15, "R6 len5 on3");
    endtask

    task automatic t_edges_indep();
        do_reset();
        bus_write(12'h424, 32'd0);
        bus_write(12'h404, 32'd4);
        bus_write(12'h428, 32'd7);
        bus_write(12'h408, 32'd4);
        check_wave(1, 4, 0, 0, 0, 0, 8, "R6 on0 low / R11");
        check_wave(2, 4, 7, 0, 0, 8, 8, "R6 on>=len high / R11");
        check(pwm[0] === 1'b0 && pwm[3] === 1'b0, "R11 untouched channels",
              longint'(pwm), 0);
    endtask

    task automatic t_divider();
        for (int s = 0; s < 4; s++) begin
            do_reset();
            bus_write(12'h44C, 32'(s));
            bus_write(12'h42C, 32'd2);
            bus_write(12'h40C, 32'd3);
            check_wave(3, 3, 2, s, 0, 0, 6 * (1 << s) + 1, $sformatf("R7 sel%0d", s));
        end
    endtask

    task automatic t_invert();
        do_reset();
        bus_write(12'h440, 32'h20);
        bus_write(12'h420, 32'd1);
        bus_write(12'h400, 32'd4);
        check_wave(0, 4, 1, 0, 1, 0, 12, "R8 inverted");
    endtask

    task automatic t_stage_commit();
        do_reset();
        bus_write(12'h420, 32'd2);
        bus_write(12'h400, 32'd4);
        check_wave(0, 4, 2, 0, 0, 0, 5, "R9 initial");
        bus_write(12'h420, 32'd0);
        bus_write(12'h440, 32'h20);
        check_wave(0, 4, 2, 0, 0, 5, 7, "R4 staged only");
        bus_write(12'h400, 32'd6);
        check_wave(0, 4, 2, 0, 0, 12, 4, "R9 old until end");
        check_wave(0, 6, 0, 0, 1, 0, 12, "R9 new set live");
    endtask

    task automatic t_collide();
        do_reset();
        bus_write(12'h420, 32'd1);
        bus_write(12'h400, 32'd3);
        check_wave(0, 3, 1, 0, 0, 0, 2, "R9 pre-collision");
        bus_write(12'h420, 32'd4);
        step_write(12'h400, 32'd5);
        check_wave(0, 3, 1, 0, 0, 3, 3, "R9 collision wraps old");
        check_wave(0, 5, 4, 0, 0, 0, 10, "R9 collision new set");
    endtask

    task automatic t_disable();
        bit ok = 1'b1;
        do_reset();
        bus_write(12'h420, 32'd3);
        bus_write(12'h400, 32'd3);
        check_wave(0, 3, 3, 0, 0, 0, 1, "R10 running");
        bus_write(12'h440, 32'h20);
        bus_write(12'h400, 32'd0);
        check_wave(0, 3, 3, 0, 0, 1, 2, "R10 finishes cycle");
        for (int k = 0; k < 10; k++) begin
            if (pwm[0] !== 1'b0) ok = 1'b0;
            step();
        end
        check(ok, "R10 held low", longint'(ok), 1);
        bus_write(12'h400, 32'd4);
        check_wave(0, 4, 3, 0, 1, 0, 8, "R5 restart from stop");
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_regmap();
        t_unmapped();
        t_basic();
        t_edges_indep();
        t_divider();
        t_invert();
        t_stage_commit();
        t_collide();
        t_disable();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule